// File: doc/BRIEF.md
# Prioritised Interrupt Entry Sequencer

This block sits beside a CPU's execution unit and decides, at each instruction boundary, whether an interrupt is taken and which one. Four request classes compete: a software or exception request whose 8-bit type comes from the instruction decoder (divide error, overflow trap, INT n), the non-maskable input, the maskable input (honoured only while the interrupt-enable flag is set), and the single-step trap (raised while the trap flag is set). The winner's type selects an entry in a 256-entry vector table of 4-byte IP:CS pairs at physical address 0.

Once a request is accepted the block runs the entry sequence by itself through a simple request/acknowledge memory port. It pushes the flags word, signals that the interrupt-enable and trap flags must be cleared, pushes CS and then IP, reads the new IP and then the new CS from the table, and finally strobes `done` with the new CS:IP and the lowered stack pointer. The register file receives these values and does not take part in the sequence.

Top module: `irq_entry_seq`

## Requirements
- R1: Vector reads go to physical address type*4 for the new IP and type*4+2 for the new CS, so every read lies in 0x00000..0x003FF.
- R2: When several requests are pending at one boundary the winner is, from highest to lowest: software/exception request, non-maskable, maskable, single-step.
- R3: The maskable request is ignored while flags bit 9 (interrupt enable) is clear; the non-maskable request is taken regardless of that bit.
- R4: A rising edge on `nmi_in` is held pending until it is serviced; a level that stays high afterwards causes no further entry.
- R5: Types: software/exception uses `sw_type`, single-step uses 1, non-maskable uses 2, maskable uses `intr_type`, captured at acceptance, which is marked by a one-cycle `intr_ack`.
- R6: The memory operations of one entry are, in order: write flags at SS:SP-2, write CS at SS:SP-4, write IP at SS:SP-6 (each push lowers SP by 2 before writing), read IP, read CS. Physical address is SS*16+offset, 20 bits.
- R7: `clr_flags` pulses once, in the cycle the flags write is acknowledged, with `new_flags` equal to the saved flags with bit 9 (interrupt enable) and bit 8 (trap) cleared.
- R8: `done` pulses for one cycle after the CS read, with `new_ip`, `new_cs` holding the read data and `new_sp` equal to SP-6.
- R9: Requests are sampled only in a cycle with `boundary` high while the block is idle; nothing is accepted while `busy` is high.
- R10: A memory request keeps its address, direction and write data stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary | input | 1 | Instruction-boundary strobe |
| sw_req | input | 1 | Software/exception interrupt request |
| sw_type | input | 8 | Type of the software/exception request |
| nmi_in | input | 1 | Non-maskable input, edge-sensitive |
| intr_req | input | 1 | Maskable interrupt request |
| intr_type | input | 8 | Acknowledge byte for the maskable request |
| intr_ack | output | 1 | Maskable request accepted |
| flags_in | input | 16 | Current flags word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return instruction pointer |
| ss_in | input | 16 | Stack segment |
| sp_in | input | 16 | Current stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| clr_flags | output | 1 | Clear interrupt-enable and trap flags |
| new_flags | output | 16 | Flags value to load with `clr_flags` |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Entry complete |
| new_ip | output | 16 | Handler IP |
| new_cs | output | 16 | Handler CS |
| new_sp | output | 16 | Stack pointer after the three pushes |

## Verification
The hardest situation to reach is a non-maskable edge that arrives while a higher-priority request also wants the same boundary, then must survive until a later boundary while the input stays high. The bench raises all four request classes at once, holds `nmi_in` high throughout, and steps boundary by boundary so each class wins in turn and the lingering level is shown to start nothing. A sweep over all 256 software types checks every table address and the full push order.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W = 16;
  localparam int PADDR_W = 20;
  localparam int TYPE_W = 8;
  localparam int IF_BIT = 9;
  localparam int TF_BIT = 8;
  localparam logic [TYPE_W-1:0] TRAP_TYPE = 8'd1;
  localparam logic [TYPE_W-1:0] NMI_TYPE = 8'd2;

  typedef enum logic [1:0] {
    SRC_SW   = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_INTR = 2'd2,
    SRC_TRAP = 2'd3
  } irq_src_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PSHF = 3'd1,
    ST_PSHC = 3'd2,
    ST_PSHI = 3'd3,
    ST_RDIP = 3'd4,
    ST_RDCS = 3'd5,
    ST_DONE = 3'd6
  } entry_st_e;
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  output logic pend
);
  logic nmi_q;
  logic pend_q;
  logic pend_d;
  logic rise;

  assign rise   = nmi_in & ~nmi_q;
  assign pend_d = rise | (pend_q & ~take);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_in;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_pkg::*;
(
  input  logic              sw_req,
  input  logic [TYPE_W-1:0] sw_type,
  input  logic              nmi_pend,
  input  logic              intr_req,
  input  logic [TYPE_W-1:0] intr_type,
  input  logic              if_en,
  input  logic              tf_en,
  output logic              win_valid,
  output irq_src_e          win_src,
  output logic [TYPE_W-1:0] win_type
);
  always_comb begin
    win_valid = 1'b1;
    win_src   = SRC_SW;
    win_type  = sw_type;
    if (sw_req) begin
      win_src  = SRC_SW;
      win_type = sw_type;
    end else if (nmi_pend) begin
      win_src  = SRC_NMI;
      win_type = NMI_TYPE;
    end else if (intr_req && if_en) begin
      win_src  = SRC_INTR;
      win_type = intr_type;
    end else if (tf_en) begin
      win_src  = SRC_TRAP;
      win_type = TRAP_TYPE;
    end else begin
      win_valid = 1'b0;
    end
  end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_pkg::*;
#(
  parameter logic [PADDR_W-1:0] VEC_BASE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [TYPE_W-1:0]  acc_type,
  input  logic [DATA_W-1:0]  flags_in,
  input  logic [DATA_W-1:0]  cs_in,
  input  logic [DATA_W-1:0]  ip_in,
  input  logic [DATA_W-1:0]  ss_in,
  input  logic [DATA_W-1:0]  sp_in,
  input  logic               mem_ack,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [PADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               clr_flags,
  output logic [DATA_W-1:0]  new_flags,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  new_ip,
  output logic [DATA_W-1:0]  new_cs,
  output logic [DATA_W-1:0]  new_sp
);
  localparam logic [DATA_W-1:0] CLR_MASK = DATA_W'((1 << IF_BIT) | (1 << TF_BIT));
  localparam int SEG_SH = PADDR_W - DATA_W;

  entry_st_e st_q, st_d;
  logic [TYPE_W-1:0] typ_q;
  logic [DATA_W-1:0] fl_q, cs_q, ip_q, ss_q, sp_q, sp_d;
  logic [DATA_W-1:0] nip_q, ncs_q;
  logic cap_en, ip_en, cs_en, sp_en;

  logic [PADDR_W-1:0] stk_addr;
  logic [PADDR_W-1:0] vec_addr;

  assign stk_addr = {ss_q, {SEG_SH{1'b0}}} + {{SEG_SH{1'b0}}, sp_q};
  assign vec_addr = VEC_BASE + {{(PADDR_W-TYPE_W-2){1'b0}}, typ_q, 2'b00};

  // next state
  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    ip_en  = 1'b0;
    cs_en  = 1'b0;
    sp_en  = 1'b0;
    sp_d   = sp_q - DATA_W'(2);
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d   = ST_PSHF;
        cap_en = 1'b1;
        sp_en  = 1'b1;
        sp_d   = sp_in - DATA_W'(2);
      end
      ST_PSHF: if (mem_ack) begin
        st_d  = ST_PSHC;
        sp_en = 1'b1;
      end
      ST_PSHC: if (mem_ack) begin
        st_d  = ST_PSHI;
        sp_en = 1'b1;
      end
      ST_PSHI: if (mem_ack) st_d = ST_RDIP;
      ST_RDIP: if (mem_ack) begin
        st_d  = ST_RDCS;
        ip_en = 1'b1;
      end
      ST_RDCS: if (mem_ack) begin
        st_d  = ST_DONE;
        cs_en = 1'b1;
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      typ_q <= '0;
      fl_q  <= '0;
      cs_q  <= '0;
      ip_q  <= '0;
      ss_q  <= '0;
      sp_q  <= '0;
      nip_q <= '0;
      ncs_q <= '0;
    end else begin
      st_q <= st_d;
      if (cap_en) begin
        typ_q <= acc_type;
        fl_q  <= flags_in;
        cs_q  <= cs_in;
        ip_q  <= ip_in;
        ss_q  <= ss_in;
      end
      if (sp_en) sp_q <= sp_d;
      if (ip_en) nip_q <= mem_rdata;
      if (cs_en) ncs_q <= mem_rdata;
    end
  end

  // outputs
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = stk_addr;
    mem_wdata = fl_q;
    unique case (st_q)
      ST_PSHF: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = fl_q; end
      ST_PSHC: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = cs_q; end
      ST_PSHI: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = ip_q; end
      ST_RDIP: begin mem_req = 1'b1; mem_addr = vec_addr; end
      ST_RDCS: begin mem_req = 1'b1; mem_addr = vec_addr + PADDR_W'(2); end
      default: ;
    endcase
  end

  assign clr_flags = (st_q == ST_PSHF) && mem_ack;
  assign new_flags = fl_q & ~CLR_MASK;
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign new_ip    = nip_q;
  assign new_cs    = ncs_q;
  assign new_sp    = sp_q;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_pkg::*;
#(
  parameter logic [19:0] VEC_BASE = 20'h00000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary,
  input  logic        sw_req,
  input  logic [7:0]  sw_type,
  input  logic        nmi_in,
  input  logic        intr_req,
  input  logic [7:0]  intr_type,
  output logic        intr_ack,
  input  logic [15:0] flags_in,
  input  logic [15:0] cs_in,
  input  logic [15:0] ip_in,
  input  logic [15:0] ss_in,
  input  logic [15:0] sp_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [19:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [15:0] mem_rdata,
  output logic        clr_flags,
  output logic [15:0] new_flags,
  output logic        busy,
  output logic        done,
  output logic [15:0] new_ip,
  output logic [15:0] new_cs,
  output logic [15:0] new_sp
);
  logic nmi_pend;
  logic win_valid;
  irq_src_e win_src;
  logic [TYPE_W-1:0] win_type;
  logic accept;
  logic nmi_take;

  assign accept   = boundary && win_valid && !busy;
  assign nmi_take = accept && (win_src == SRC_NMI);
  assign intr_ack = accept && (win_src == SRC_INTR);

  irq_nmi_edge u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_in (nmi_in),
    .take   (nmi_take),
    .pend   (nmi_pend)
  );

  irq_prio_arb u_arb (
    .sw_req    (sw_req),
    .sw_type   (sw_type),
    .nmi_pend  (nmi_pend),
    .intr_req  (intr_req),
    .intr_type (intr_type),
    .if_en     (flags_in[IF_BIT]),
    .tf_en     (flags_in[TF_BIT]),
    .win_valid (win_valid),
    .win_src   (win_src),
    .win_type  (win_type)
  );

  irq_entry_fsm #(.VEC_BASE(VEC_BASE)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .acc_type  (win_type),
    .flags_in  (flags_in),
    .cs_in     (cs_in),
    .ip_in     (ip_in),
    .ss_in     (ss_in),
    .sp_in     (sp_in),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .clr_flags (clr_flags),
    .new_flags (new_flags),
    .busy      (busy),
    .done      (done),
    .new_ip    (new_ip),
    .new_cs    (new_cs),
    .new_sp    (new_sp)
  );
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        intr_ack,
  input logic        mem_req,
  input logic        mem_we,
  input logic [19:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        mem_ack,
  input logic        clr_flags,
  input logic        busy,
  input logic        done
);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R1
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> mem_addr <= 20'h003FF);

  // R9
  idle_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ack |-> !busy);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intr_ack |=> busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R7
  clr_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flags |-> mem_req && mem_we && mem_ack);
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .intr_ack  (intr_ack),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .clr_flags (clr_flags),
  .busy      (busy),
  .done      (done)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 1'b0, sw_req = 1'b0, nmi_in = 1'b0, intr_req = 1'b0;
  logic [7:0] sw_type = '0, intr_type = '0;
  logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, ss_in = '0, sp_in = '0;
  logic intr_ack, mem_req, mem_we, clr_flags, busy, done;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, new_flags, new_ip, new_cs, new_sp;
  logic mem_ack;
  logic [15:0] mem_rdata;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  irq_entry_seq i_irq_entry_seq (.*);

  // memory model: one wait cycle per access, data derived from address
  assign mem_rdata = mem_addr[15:0] ^ 16'hA5A5;
  logic log_clr = 1'b0;
  logic [19:0] la [8];
  logic [15:0] ld [8];
  logic        lw [8];
  int opcnt;
  int clr_at, clr_cnt, ack_cnt;
  logic [15:0] nf_cap;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      opcnt <= 0; clr_at <= -1; clr_cnt <= 0; ack_cnt <= 0; nf_cap <= '0;
    end else begin
      mem_ack <= mem_req & ~mem_ack;
      if (log_clr) begin
        opcnt <= 0; clr_at <= -1; clr_cnt <= 0; ack_cnt <= 0;
      end else begin
        if (mem_req && mem_ack) begin
          if (opcnt < 8) begin
            la[opcnt] <= mem_addr;
            ld[opcnt] <= mem_we ? mem_wdata : mem_rdata;
            lw[opcnt] <= mem_we;
          end
          opcnt <= opcnt + 1;
        end
        if (clr_flags) begin
          clr_at <= opcnt; clr_cnt <= clr_cnt + 1; nf_cap <= new_flags;
        end
        if (intr_ack) ack_cnt <= ack_cnt + 1;
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic pulse_boundary();
    @(negedge clk); boundary = 1'b1;
    @(negedge clk); boundary = 1'b0;
  endtask

  // waits for done; returns 0 on timeout
  task automatic wait_done(output logic got);
    got = 1'b0;
    for (int i = 0; i < 100; i++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic entry(input logic [7:0] exp_t, input string tag);
    logic got;
    logic [19:0] base, va;
    logic [15:0] fl, cs, ip, sp;
    fl = flags_in; cs = cs_in; ip = ip_in; sp = sp_in;
    base = {ss_in, 4'h0};
    va = {10'd0, exp_t, 2'b00};
    clear_log();
    pulse_boundary();
    wait_done(got);
    chk(got, {tag, " R8 done"}, got, 1);
    chk(new_ip == (va[15:0] ^ 16'hA5A5), {tag, " R8 new_ip"}, new_ip, va[15:0] ^ 16'hA5A5);
    chk(new_cs == ((va[15:0] + 16'd2) ^ 16'hA5A5), {tag, " R8 new_cs"}, new_cs, (va[15:0] + 16'd2) ^ 16'hA5A5);
    chk(new_sp == sp - 16'd6, {tag, " R8 new_sp"}, new_sp, sp - 16'd6);
    @(negedge clk);
    chk(opcnt == 5, {tag, " R6 op count"}, opcnt, 5);
    chk(lw[0] && la[0] == base + {4'h0, sp - 16'd2} && ld[0] == fl, {tag, " R6 push flags"}, la[0], base + {4'h0, sp - 16'd2});
    chk(lw[1] && la[1] == base + {4'h0, sp - 16'd4} && ld[1] == cs, {tag, " R6 push cs"}, la[1], base + {4'h0, sp - 16'd4});
    chk(lw[2] && la[2] == base + {4'h0, sp - 16'd6} && ld[2] == ip, {tag, " R6 push ip"}, la[2], base + {4'h0, sp - 16'd6});
    chk(!lw[3] && la[3] == va, {tag, " R1 ip read addr"}, la[3], va);
    chk(!lw[4] && la[4] == va + 20'd2, {tag, " R1 cs read addr"}, la[4], va + 20'd2);
    chk(clr_cnt == 1 && clr_at == 0, {tag, " R7 clear position"}, clr_at, 0);
    chk(nf_cap == (fl & 16'hFCFF), {tag, " R7 new_flags"}, nf_cap, fl & 16'hFCFF);
  endtask

  task automatic expect_idle(input string tag);
    clear_log();
    pulse_boundary();
    repeat (12) @(negedge clk);
    chk(!busy && opcnt == 0, tag, opcnt, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ss_in = 16'h5000; sp_in = 16'h0100; cs_in = 16'h2000; ip_in = 16'h0042;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !clr_flags && !intr_ack, "reset outputs idle", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R5 R6: sweep all software types
    for (int t = 0; t < 256; t++) begin
      sw_req = 1'b1; sw_type = 8'(t);
      flags_in = 16'h0200 | 16'(t);
      sp_in = 16'h0100 + 16'(t * 8);
      ip_in = 16'(t * 3);
      entry(8'(t), "R5 sw sweep");
    end
    sw_req = 1'b0;

    // R9: no boundary, no entry
    clear_log();
    sw_req = 1'b1; sw_type = 8'h21;
    repeat (10) @(negedge clk);
    chk(!busy && opcnt == 0, "R9 no boundary no entry", opcnt, 0);
    sw_req = 1'b0;

    // R2 R4: all four pending; NMI held high throughout
    flags_in = 16'h0300;
    nmi_in = 1'b1; intr_req = 1'b1; intr_type = 8'h40;
    sw_req = 1'b1; sw_type = 8'h00;
    repeat (2) @(negedge clk);
    entry(8'h00, "R2 sw over nmi");
    chk(ack_cnt == 0, "R5 no intr_ack for sw", ack_cnt, 0);
    sw_req = 1'b0;
    entry(8'h02, "R2 R4 nmi pending");
    entry(8'h40, "R2 intr over trap");
    chk(ack_cnt == 1, "R5 intr_ack once", ack_cnt, 1);
    intr_req = 1'b0;
    entry(8'h01, "R2 trap last");
    flags_in = 16'h0200;
    expect_idle("R4 held nmi level no re-entry");

    // R3: maskable ignored with IF clear, NMI still taken
    flags_in = 16'h0000; intr_req = 1'b1; intr_type = 8'h08;
    nmi_in = 1'b0;
    expect_idle("R3 intr masked");
    @(negedge clk); nmi_in = 1'b1;
    repeat (2) @(negedge clk);
    entry(8'h02, "R3 nmi with IF clear");
    nmi_in = 1'b0;

    // R3 R5: maskable type sweep with IF set
    flags_in = 16'h0200;
    for (int t = 0; t < 256; t += 17) begin
      intr_type = 8'(t);
      entry(8'(t), "R5 intr type");
    end
    intr_req = 1'b0;

    // R9: boundary during busy is ignored
    sw_req = 1'b1; sw_type = 8'h04;
    clear_log();
    pulse_boundary();
    @(negedge clk); boundary = 1'b1;
    repeat (3) @(negedge clk); boundary = 1'b0; sw_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(opcnt == 5 && clr_cnt == 1, "R9 single entry while busy", opcnt, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule